// File: doc/BRIEF.md
# Loop Counter Branch Unit

This block executes the counted-loop branch primitive of a small processor core. It receives one postbyte and one offset byte per instruction. The postbyte says whether to decrement, increment or only test a register, which of eight registers to use, the sense of the branch condition and the sign of the branch offset. The unit reads the selected register through a register-file read port, adjusts the value, and decides whether the loop branch is taken. The decision depends on whether the adjusted value is zero.

The PC input already points past the instruction bytes. The branch target is that PC plus the offset. The offset is nine bits wide: the offset byte is the low part and the postbyte sign bit is the top bit. On every legal instruction the adjusted value goes back to the register file, whether or not the branch is taken. An illegal operation code suppresses both the writeback and the branch, and raises a flag instead.

The register read is combinational, inside the issue cycle. All results are registered and appear one clock after the instruction is presented.

Top module: `loop_branch_unit`

## Requirements
- R1: After a synchronous reset, out_valid, br_taken, rf_wr_en and illegal_op are 0, and br_target and rf_wr_data are 0.
- R2: Postbyte bits 7:6 select the operation. 00 subtracts one from the register value, 01 leaves it unchanged, and 10 adds one. The arithmetic wraps modulo the register width.
- R3: br_target equals pc_next plus the signed 9-bit offset, modulo 2^16. Postbyte bit 4 is the sign: when it is 1, the upper byte of the offset is all ones, and when it is 0, the upper byte is zero. The offset byte forms the low eight bits.
- R4: Postbyte bit 5 is the branch sense. With bit 5 = 1 the branch is taken when the adjusted value is nonzero. With bit 5 = 0 the branch is taken when the adjusted value is zero.
- R5: Postbyte bits 2:0 select the register. rf_rd_sel equals those bits in the issue cycle, and rf_wr_sel equals them in the result cycle. The codes are 0=A, 1=B, 2=condition codes, 3=scratch, 4=D, 5=X, 6=Y, 7=SP.
- R6: Codes 0 to 3 are 8-bit registers. For these, only the low 8 bits of rf_rd_data are used, the zero test looks at 8 bits, and rf_wr_data has its upper 8 bits at 0. Codes 4 to 7 use all 16 bits.
- R7: For a legal operation, rf_wr_en is 1 in the result cycle whatever the branch outcome, and rf_wr_data holds the adjusted value.
- R8: Postbyte bits 7:6 = 11 set illegal_op to 1 in the result cycle, with rf_wr_en = 0 and br_taken = 0.
- R9: Results appear exactly one cycle after in_valid. In a cycle that follows a cycle with in_valid low, out_valid, br_taken, rf_wr_en and illegal_op are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction presented this cycle |
| postbyte | input | 8 | Operation, sense, offset sign and register selector |
| offset_byte | input | 8 | Low byte of the branch offset |
| pc_next | input | 16 | PC after the instruction bytes |
| rf_rd_sel | output | 3 | Register-file read selector (combinational) |
| rf_rd_data | input | 16 | Register-file read data for rf_rd_sel |
| out_valid | output | 1 | Result cycle marker |
| br_taken | output | 1 | Load the PC with br_target |
| br_target | output | 16 | PC-relative branch target |
| rf_wr_en | output | 1 | Write rf_wr_data into register rf_wr_sel |
| rf_wr_sel | output | 3 | Writeback register selector |
| rf_wr_data | output | 16 | Adjusted register value |
| illegal_op | output | 1 | Operation code 11 was presented |

## Verification
The register read selector follows the postbyte in the same cycle. The bench checks it while the instruction is still held, before the rising edge. The branch flag, target, writeback and illegal flag are due one rising edge after in_valid, and the bench samples them at the following falling edge. The bench then drops in_valid for one cycle and checks at the next falling edge that all strobes have cleared. The sweep covers every operation, sense, sign and register code, across register values at the zero, wrap and byte-boundary edges.

// File: rtl/lcb_pkg.sv
package lcb_pkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;
  localparam int SEL_W  = 3;

  typedef enum logic [1:0] {
    OP_DEC = 2'b00,
    OP_TST = 2'b01,
    OP_INC = 2'b10,
    OP_BAD = 2'b11
  } loop_op_e;

  typedef struct packed {
    loop_op_e         op;
    logic             sense_nz;
    logic             off_neg;
    logic [SEL_W-1:0] sel;
    logic             narrow;
  } loop_dec_t;
endpackage

// File: rtl/lcb_decode.sv
module lcb_decode
  import lcb_pkg::*;
(
  input  logic [7:0] postbyte,
  output loop_dec_t  dec
);
  localparam int NARROW_CODES = 4;

  always_comb begin
    dec.op       = loop_op_e'(postbyte[7:6]);
    dec.sense_nz = postbyte[5];
    dec.off_neg  = postbyte[4];
    dec.sel      = postbyte[SEL_W-1:0];
    dec.narrow   = (int'(postbyte[SEL_W-1:0]) < NARROW_CODES);
  end
endmodule

// File: rtl/lcb_adjust.sv
module lcb_adjust
  import lcb_pkg::*;
#(
  parameter int WIDTH  = DATA_W,
  parameter int NARROW = BYTE_W
) (
  input  logic [WIDTH-1:0] value_in,
  input  loop_op_e         op,
  input  logic             narrow,
  output logic [WIDTH-1:0] value_out,
  output logic             is_zero
);
  localparam logic [WIDTH-1:0] LOW_MASK = {{(WIDTH-NARROW){1'b0}}, {NARROW{1'b1}}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] src;
  logic [WIDTH-1:0] raw;

  always_comb begin
    src = narrow ? (value_in & LOW_MASK) : value_in;
    unique case (op)
      OP_DEC:  raw = src - ONE;
      OP_INC:  raw = src + ONE;
      default: raw = src;
    endcase
    value_out = narrow ? (raw & LOW_MASK) : raw;
    is_zero   = (value_out == '0);
  end
endmodule

// File: rtl/lcb_target.sv
module lcb_target
  import lcb_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = BYTE_W
) (
  input  logic [AW-1:0] pc_next,
  input  logic [OW-1:0] off_lo,
  input  logic          off_neg,
  output logic [AW-1:0] target
);
  logic [AW-1:0] offset_ext;

  always_comb begin
    offset_ext = {{(AW-OW){off_neg}}, off_lo};
    target     = pc_next + offset_ext;
  end
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
  import lcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        postbyte,
  input  logic [BYTE_W-1:0] offset_byte,
  input  logic [ADDR_W-1:0] pc_next,
  output logic [SEL_W-1:0]  rf_rd_sel,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              out_valid,
  output logic              br_taken,
  output logic [ADDR_W-1:0] br_target,
  output logic              rf_wr_en,
  output logic [SEL_W-1:0]  rf_wr_sel,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              illegal_op
);
  loop_dec_t         dec;
  logic [DATA_W-1:0] adj_val;
  logic              adj_zero;
  logic [ADDR_W-1:0] tgt;
  logic              legal;
  logic              take;

  lcb_decode u_dec (.postbyte(postbyte), .dec(dec));

  lcb_adjust #(.WIDTH(DATA_W), .NARROW(BYTE_W)) u_adj (
    .value_in(rf_rd_data), .op(dec.op), .narrow(dec.narrow),
    .value_out(adj_val), .is_zero(adj_zero)
  );

  lcb_target #(.AW(ADDR_W), .OW(BYTE_W)) u_tgt (
    .pc_next(pc_next), .off_lo(offset_byte), .off_neg(dec.off_neg), .target(tgt)
  );

  assign rf_rd_sel = dec.sel;
  assign legal     = (dec.op != OP_BAD);
  assign take      = legal && (dec.sense_nz ? !adj_zero : adj_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      br_taken   <= 1'b0;
      br_target  <= '0;
      rf_wr_en   <= 1'b0;
      rf_wr_sel  <= '0;
      rf_wr_data <= '0;
      illegal_op <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      br_taken   <= in_valid && take;
      rf_wr_en   <= in_valid && legal;
      illegal_op <= in_valid && !legal;
      if (in_valid) begin
        br_target  <= tgt;
        rf_wr_sel  <= dec.sel;
        rf_wr_data <= adj_val;
      end
    end
  end

  // R8
  wr_vs_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    !(rf_wr_en && illegal_op));

  // R7
  legal_writes_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (rf_wr_en || illegal_op));

  // R9
  strobe_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (br_taken || rf_wr_en || illegal_op) |-> out_valid);

  // R4
  sense_rule_chk: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> (br_taken == ($past(postbyte[5]) ? (rf_wr_data != '0) : (rf_wr_data == '0))));

  // R6
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_wr_en && !rf_wr_sel[SEL_W-1]) |-> (rf_wr_data[DATA_W-1:BYTE_W] == '0));

  // R5
  wr_sel_follows_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (rf_wr_sel == $past(postbyte[SEL_W-1:0])));
endmodule

// File: tb/tb_loop_branch_unit.sv
`timescale 1ns/1ps
module tb_loop_branch_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [7:0]  postbyte;
  logic [7:0]  offset_byte;
  logic [15:0] pc_next;
  logic [2:0]  rf_rd_sel;
  logic [15:0] rf_rd_data;
  logic        out_valid, br_taken, rf_wr_en, illegal_op;
  logic [15:0] br_target, rf_wr_data;
  logic [2:0]  rf_wr_sel;

  logic [15:0] regs [8];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always_comb rf_rd_data = regs[rf_rd_sel];

  loop_branch_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .postbyte(postbyte),
    .offset_byte(offset_byte), .pc_next(pc_next), .rf_rd_sel(rf_rd_sel),
    .rf_rd_data(rf_rd_data), .out_valid(out_valid), .br_taken(br_taken),
    .br_target(br_target), .rf_wr_en(rf_wr_en), .rf_wr_sel(rf_wr_sel),
    .rf_wr_data(rf_wr_data), .illegal_op(illegal_op)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [1:0] op, input bit sense, input bit neg,
                         input logic [2:0] sel, input logic [15:0] val,
                         input logic [7:0] off, input logic [15:0] pc);
    logic [15:0] src, adj, tgt;
    bit narrow, zero, take, legal;
    narrow = (sel < 3'd4);
    src = narrow ? (val & 16'h00FF) : val;
    case (op)
      2'b00: adj = src - 16'd1;
      2'b10: adj = src + 16'd1;
      default: adj = src;
    endcase
    if (narrow) adj = adj & 16'h00FF;
    zero  = (adj == 16'd0);
    legal = (op != 2'b11);
    take  = legal && (sense ? !zero : zero);
    tgt   = pc + {{8{neg}}, off};

    regs[sel]   = val;
    postbyte    = {op, sense, neg, 1'b0, sel};
    offset_byte = off;
    pc_next     = pc;
    in_valid    = 1'b1;
    #1;
    chk("R5 rd_sel", {29'd0, rf_rd_sel}, {29'd0, sel});
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 out_valid", {31'd0, out_valid}, 32'd1);
    chk("R8 illegal_op", {31'd0, illegal_op}, {31'd0, !legal});
    chk("R7 wr_en", {31'd0, rf_wr_en}, {31'd0, legal});
    chk("R4 taken", {31'd0, br_taken}, {31'd0, take});
    chk("R3 target", {16'd0, br_target}, {16'd0, tgt});
    chk("R5 wr_sel", {29'd0, rf_wr_sel}, {29'd0, sel});
    if (legal) begin
      if (narrow) chk("R6 wr_data narrow", {16'd0, rf_wr_data}, {16'd0, adj});
      else        chk("R2 wr_data", {16'd0, rf_wr_data}, {16'd0, adj});
    end
    @(negedge clk);
    chk("R9 idle strobes", {28'd0, out_valid, br_taken, rf_wr_en, illegal_op}, 32'd0);
  endtask

  initial begin
    logic [15:0] vals [7];
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'hFFFF; vals[3] = 16'h00FF;
    vals[4] = 16'h0100; vals[5] = 16'h1280; vals[6] = 16'h0002;
    for (int i = 0; i < 8; i++) regs[i] = 16'h0;
    rst = 1'b1; in_valid = 1'b0; postbyte = 8'h0; offset_byte = 8'h0; pc_next = 16'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset strobes", {28'd0, out_valid, br_taken, rf_wr_en, illegal_op}, 32'd0);
    chk("R1 reset data", {br_target, rf_wr_data}, 32'd0);
    for (int op = 0; op < 4; op++)
      for (int s = 0; s < 2; s++)
        for (int n = 0; n < 2; n++)
          for (int r = 0; r < 8; r++)
            for (int v = 0; v < 7; v++)
              run_vec(2'(op), s[0], n[0], 3'(r), vals[v],
                      8'(v * 37 + r * 11 + 3), 16'(16'hFFF0 + op * 4099 + v * 257));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule